// File: doc/BRIEF.md
# GPIO Input Debounce Filter

This block sits between a synchronized GPIO input and the logic that samples pin status and detects interrupts. It suppresses pulses shorter than a programmed interval so that contact bounce and short noise never reach that logic. Time is measured in pulses of a slow reference strobe, `ref_tick`, which is high for one system clock cycle per reference period of about 30.5 µs (a 32.768 kHz reference).

The interval is a 4-bit multiplier times one of four reference-tick units. A 2-bit mode field selects one of four behaviours:

- pass the pin straight through;
- filter both directions;
- let falling edges through at once and filter only rising edges;
- let rising edges through at once and filter only falling edges.

A four-state machine holds the filtered level. Two states are stable: `S_LOW` and `S_HIGH`. Two states are pending: `S_RISE_WAIT` and `S_FALL_WAIT`. The transitions are:

- **start**: from `S_LOW` to `S_RISE_WAIT`, or from `S_HIGH` to `S_FALL_WAIT`, when the pin differs from the stable level and that edge is filtered.
- **abort**: from a pending state back to the stable state it came from, when the pin returns to the old level.
- **commit**: from `S_RISE_WAIT` to `S_HIGH`, or from `S_FALL_WAIT` to `S_LOW`, when the interval expires.
- **pass**: an unfiltered edge that moves the state directly to the new stable state, from either the stable or the pending state.
- **follow**: in pass-through mode, the state is forced to match the pin.

Top module: `gpio_debounce_filter`

## Requirements
- R1: While `rst_n` is low and after it rises, `pin_out` is 0 and the state is `S_LOW`, until the pin or the mode moves it.
- R2: With `filt_kind` = 2'b00, `pin_out` equals `pin_in` in the same cycle, with no delay.
- R3: `unit_sel` sets the unit: 2'b00 = 2 ticks, 2'b01 = 8 ticks, 2'b10 = 512 ticks, 2'b11 = 2048 ticks.
- R4: The interval is `db_count` × unit, counted only in cycles where `ref_tick` is 1. The output commits on the clock edge that samples the final tick, so `pin_out` changes one cycle after that tick is presented.
- R5: `db_count` = 0 with filtering on gives an interval of exactly one unit.
- R6: With `filt_kind` = 2'b11, both rising and falling changes reach `pin_out` only after the pin has held the new level for the full interval.
- R7: A return of the pin to the current filtered level during a pending interval aborts it. A later change starts counting from zero.
- R8: With `filt_kind` = 2'b01, a low pin drives `pin_out` low on the next clock edge, even while a rise is pending. Rising changes are filtered as in R6.
- R9: With `filt_kind` = 2'b10, a high pin drives `pin_out` high on the next clock edge, even while a fall is pending. Falling changes are filtered as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe per reference period |
| pin_in | input | 1 | Synchronized raw pin level |
| filt_kind | input | 2 | 00 pass-through, 01 fast fall, 10 fast rise, 11 filter both |
| unit_sel | input | 2 | Unit code: 2, 8, 512 or 2048 ticks |
| db_count | input | CNT_W | Interval multiplier, where 0 means 1 |
| pin_out | output | 1 | Filtered level |

## Verification
The tightest cases arise when a pending interval reaches its last tick in the same cycle that another event occurs. That event is either the pin returning to the old level, or the mode changing to a fast-edge type or to pass-through. The bench holds the pin for a chosen number of cycles while the strobe runs at one pulse every three clocks, so these events land exactly on the expiring tick, one cycle before it and one cycle after it. A behavioural tick-counting model is compared with `pin_out` on every clock. Explicit checks confirm the output level at each boundary.

// File: rtl/gdb_pkg.sv
package gdb_pkg;
    typedef enum logic [1:0] {
        FK_PASS      = 2'b00,
        FK_FAST_FALL = 2'b01,
        FK_FAST_RISE = 2'b10,
        FK_BOTH      = 2'b11
    } filt_kind_e;

    typedef enum logic [1:0] {
        S_LOW       = 2'b00,
        S_RISE_WAIT = 2'b01,
        S_HIGH      = 2'b10,
        S_FALL_WAIT = 2'b11
    } dbs_state_e;
endpackage

// File: rtl/gdb_span_calc.sv
module gdb_span_calc #(
    parameter int CNT_W  = 4,
    parameter int UNIT_0 = 2,
    parameter int UNIT_1 = 8,
    parameter int UNIT_2 = 512,
    parameter int UNIT_3 = 2048,
    parameter int SPAN_W = 16
) (
    input  logic [CNT_W-1:0]  count,
    input  logic [1:0]        unit_sel,
    output logic [SPAN_W-1:0] span
);
    logic [SPAN_W-1:0] unit_tab [4];
    logic [SPAN_W-1:0] mult;

    for (genvar g = 0; g < 4; g++) begin : g_unit
        localparam int U = (g == 0) ? UNIT_0 : (g == 1) ? UNIT_1 :
                           (g == 2) ? UNIT_2 : UNIT_3;
        assign unit_tab[g] = SPAN_W'(U);
    end

    always_comb begin
        mult = (count == '0) ? SPAN_W'(1) : SPAN_W'(count);
        span = mult * unit_tab[unit_sel];
    end
endmodule

// File: rtl/gdb_tick_timer.sv
module gdb_tick_timer #(
    parameter int SPAN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic [SPAN_W-1:0] target,
    output logic              expire
);
    logic [SPAN_W-1:0] cnt_q;
    logic [SPAN_W-1:0] cnt_inc;

    always_comb begin
        cnt_inc = cnt_q + SPAN_W'(1);
        expire  = step && (cnt_inc >= target);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clear) cnt_q <= '0;
        else if (step)  cnt_q <= cnt_inc;
    end
endmodule

// File: rtl/gpio_debounce_filter.sv
module gpio_debounce_filter
    import gdb_pkg::*;
#(
    parameter int CNT_W        = 4,
    parameter int UNIT_TICKS_0 = 2,
    parameter int UNIT_TICKS_1 = 8,
    parameter int UNIT_TICKS_2 = 512,
    parameter int UNIT_TICKS_3 = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             pin_in,
    input  logic [1:0]       filt_kind,
    input  logic [1:0]       unit_sel,
    input  logic [CNT_W-1:0] db_count,
    output logic             pin_out
);
    localparam int MAX_A    = (UNIT_TICKS_0 > UNIT_TICKS_1) ? UNIT_TICKS_0 : UNIT_TICKS_1;
    localparam int MAX_B    = (UNIT_TICKS_2 > UNIT_TICKS_3) ? UNIT_TICKS_2 : UNIT_TICKS_3;
    localparam int MAX_UNIT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_SPAN = MAX_UNIT * ((2 ** CNT_W) - 1);
    localparam int SPAN_W   = $clog2(MAX_SPAN + 1) + 1;

    dbs_state_e        state_q, state_d;
    filt_kind_e        kind;
    logic              level, waiting, fast_rise, fast_fall;
    logic              differs, tmr_step, tmr_clear, expire;
    logic [SPAN_W-1:0] span;

    gdb_span_calc #(
        .CNT_W (CNT_W), .UNIT_0(UNIT_TICKS_0), .UNIT_1(UNIT_TICKS_1),
        .UNIT_2(UNIT_TICKS_2), .UNIT_3(UNIT_TICKS_3), .SPAN_W(SPAN_W)
    ) u_span (
        .count   (db_count),
        .unit_sel(unit_sel),
        .span    (span)
    );

    gdb_tick_timer #(.SPAN_W(SPAN_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tmr_clear),
        .step  (tmr_step),
        .target(span),
        .expire(expire)
    );

    always_comb begin
        kind      = filt_kind_e'(filt_kind);
        level     = (state_q == S_HIGH) || (state_q == S_FALL_WAIT);
        waiting   = (state_q == S_RISE_WAIT) || (state_q == S_FALL_WAIT);
        fast_rise = (kind == FK_FAST_RISE);
        fast_fall = (kind == FK_FAST_FALL);
        differs   = (pin_in != level);
        tmr_step  = waiting && differs && ref_tick;
        tmr_clear = !(waiting && differs);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_LOW;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (kind == FK_PASS) begin
            state_d = pin_in ? S_HIGH : S_LOW;
        end else begin
            unique case (state_q)
                S_LOW: begin
                    if (pin_in) state_d = fast_rise ? S_HIGH : S_RISE_WAIT;
                end
                S_RISE_WAIT: begin
                    if (!pin_in)                 state_d = S_LOW;
                    else if (fast_rise || expire) state_d = S_HIGH;
                end
                S_HIGH: begin
                    if (!pin_in) state_d = fast_fall ? S_LOW : S_FALL_WAIT;
                end
                S_FALL_WAIT: begin
                    if (pin_in)                  state_d = S_HIGH;
                    else if (fast_fall || expire) state_d = S_LOW;
                end
            endcase
        end
    end

    // output
    always_comb begin
        pin_out = (kind == FK_PASS) ? pin_in : level;
    end
endmodule

// File: rtl/gdb_checker.sv
module gdb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ref_tick,
    input logic       pin_in,
    input logic [1:0] filt_kind,
    input logic       pin_out
);
    // R1: first cycle out of reset is low
    p_reset_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && filt_kind == 2'b11) |-> !pin_out);

    // R4: in both-direction mode a rise needs a tick on the committing edge
    p_rise_needs_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_kind == 2'b11 && $past(filt_kind) == 2'b11 && $rose(pin_out))
        |-> $past(ref_tick));

    // R7: pin equal to filtered level leaves the level unchanged
    p_agree_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(filt_kind) != 2'b00 && filt_kind != 2'b00 &&
         $past(pin_in) == $past(pin_out)) |-> (pin_out == $past(pin_out)));

    // R8: fast-fall mode drops on the next edge
    p_fast_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(filt_kind) == 2'b01 && filt_kind != 2'b00 && !$past(pin_in))
        |-> !pin_out);

    // R9: fast-rise mode rises on the next edge
    p_fast_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(filt_kind) == 2'b10 && filt_kind != 2'b00 && $past(pin_in))
        |-> pin_out);
endmodule

bind gpio_debounce_filter gdb_checker u_gdb_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .pin_in   (pin_in),
    .filt_kind(filt_kind),
    .pin_out  (pin_out)
);

// File: tb/gpio_debounce_filter_test.sv
`timescale 1ns/1ps
module gpio_debounce_filter_test;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       ref_tick = 0;
    logic       pin_in = 0;
    logic [1:0] filt_kind = 2'b00;
    logic [1:0] unit_sel = 2'b00;
    logic [3:0] db_count = 4'd0;
    logic       pin_out;

    int    total = 0;
    int    bad = 0;
    bit    chk_on = 0;
    string cur_req = "R1";
    int    div_cnt = 0;

    // behavioural reference state
    bit m_lvl = 0;
    bit m_pend = 0;
    int m_ticks = 0;

    gpio_debounce_filter uut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .pin_in(pin_in),
        .filt_kind(filt_kind), .unit_sel(unit_sel), .db_count(db_count),
        .pin_out(pin_out)
    );

    always #2.5 clk = ~clk;

    // reference strobe: one pulse every three clocks
    always @(posedge clk) begin
        #1;
        div_cnt = (div_cnt + 1) % 3;
        ref_tick = (div_cnt == 0);
    end

    function automatic int unit_of(input logic [1:0] s);
        case (s)
            2'b00:   return 2;
            2'b01:   return 8;
            2'b10:   return 512;
            default: return 2048;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lvl = 0; m_pend = 0; m_ticks = 0;
        end else if (filt_kind == 2'b00) begin
            m_lvl = pin_in; m_pend = 0; m_ticks = 0;
        end else if (pin_in == m_lvl) begin
            m_pend = 0; m_ticks = 0;
        end else begin
            bit quick;
            int tgt;
            quick = (filt_kind == 2'b01 && !pin_in) || (filt_kind == 2'b10 && pin_in);
            tgt = ((db_count == 0) ? 1 : int'(db_count)) * unit_of(unit_sel);
            if (quick) begin
                m_lvl = pin_in; m_pend = 0; m_ticks = 0;
            end else if (!m_pend) begin
                m_pend = 1; m_ticks = 0;
            end else if (ref_tick) begin
                m_ticks++;
                if (m_ticks >= tgt) begin
                    m_lvl = pin_in; m_pend = 0; m_ticks = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (chk_on) begin
            bit exp;
            exp = (filt_kind == 2'b00) ? pin_in : m_lvl;
            total++;
            if (pin_out !== exp) begin
                bad++;
                $display("FAIL %s: t=%0t pin_out=%b expected=%b", cur_req, $time, pin_out, exp);
            end
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic hold(input bit v, input int n);
        pin_in = v;
        cyc(n);
    endtask

    task automatic expect_out(input string req, input bit v);
        @(negedge clk);
        total++;
        if (pin_out !== v) begin
            bad++;
            $display("FAIL %s: pin_out=%b expected=%b", req, pin_out, v);
        end
        @(posedge clk); #1;
    endtask

    task automatic cfg(input logic [1:0] k, input logic [1:0] u, input logic [3:0] c);
        filt_kind = k; unit_sel = u; db_count = c;
    endtask

    initial begin
        #(5.0 * 180000);
        bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cfg(2'b11, 2'b00, 4'd3);
        cyc(4);
        expect_out("R1", 1'b0);
        rst_n = 1;
        cyc(1);
        expect_out("R1", 1'b0);
        chk_on = 1;

        // R2 pass-through
        cur_req = "R2";
        cfg(2'b00, 2'b00, 4'd3);
        for (int i = 0; i < 12; i++) hold(i[0] ^ i[2], 1 + (i % 3));
        hold(1, 2);
        expect_out("R2", 1'b1);
        hold(0, 2);

        // R6 / R4: both-direction filter, 3 x 2 = 6 ticks
        cur_req = "R6";
        cfg(2'b11, 2'b00, 4'd3);
        hold(0, 4);
        hold(1, 14);
        hold(0, 6);
        expect_out("R6", 1'b0);
        hold(1, 40);
        expect_out("R4", 1'b1);
        hold(0, 10);
        hold(1, 5);
        expect_out("R6", 1'b1);
        for (int n = 15; n < 22; n++) begin
            hold(0, n);
            hold(1, 24);
        end
        hold(0, 30);
        expect_out("R6", 1'b0);

        // R7 restart
        cur_req = "R7";
        hold(1, 15);
        hold(0, 1);
        hold(1, 15);
        expect_out("R7", 1'b0);
        hold(1, 30);
        expect_out("R7", 1'b1);

        // R5 count zero: 8 ticks
        cur_req = "R5";
        cfg(2'b11, 2'b01, 4'd0);
        hold(0, 20);
        expect_out("R5", 1'b1);
        hold(0, 10);
        expect_out("R5", 1'b0);
        hold(1, 30);

        // R3 unit codes
        cur_req = "R3";
        cfg(2'b11, 2'b00, 4'd15);
        hold(0, 80);
        expect_out("R3", 1'b1);
        hold(0, 20);
        expect_out("R3", 1'b0);
        cfg(2'b11, 2'b10, 4'd1);
        hold(1, 1500);
        expect_out("R3", 1'b0);
        hold(1, 60);
        expect_out("R3", 1'b1);
        cfg(2'b11, 2'b11, 4'd1);
        hold(0, 6100);
        expect_out("R3", 1'b1);
        hold(0, 60);
        expect_out("R3", 1'b0);

        // R8 fast fall
        cur_req = "R8";
        cfg(2'b01, 2'b00, 4'd2);
        hold(1, 8);
        hold(0, 1);
        expect_out("R8", 1'b0);
        hold(1, 20);
        expect_out("R8", 1'b1);
        hold(0, 1);
        hold(1, 5);
        hold(0, 3);
        expect_out("R8", 1'b0);

        // R9 fast rise
        cur_req = "R9";
        cfg(2'b10, 2'b00, 4'd2);
        hold(1, 1);
        expect_out("R9", 1'b1);
        hold(0, 8);
        hold(1, 2);
        hold(0, 20);
        expect_out("R9", 1'b0);

        // mode switch while a change is pending
        cur_req = "R8";
        cfg(2'b11, 2'b01, 4'd4);
        hold(1, 40);
        hold(0, 10);
        filt_kind = 2'b01;
        cyc(2);
        expect_out("R8", 1'b0);
        cur_req = "R2";
        filt_kind = 2'b11;
        hold(1, 10);
        filt_kind = 2'b00;
        cyc(1);
        expect_out("R2", 1'b1);
        cyc(5);

        chk_on = 0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule